// File: doc/BRIEF.md
# I2C Target with Early Address Rejection

This block is the serial front end of a small control device on a two-wire I2C bus. It brings the clock and data lines into the system clock domain and finds the bus conditions: START, REPEATED START and STOP. It then tracks bits on the rising clock edges. The 7-bit target address is compared one bit at a time as it arrives. At the first bit that differs, the block stops following the bus until the next START. The same happens after any STOP, so the logic stays quiet while other devices are addressed.

When the address matches, the block acknowledges. On a write, it acknowledges every data byte and hands each one to the logic behind it with a one-cycle strobe. On a read, it asks that logic for a byte and shifts the byte out MSB first. It then reads the controller's acknowledge bit. An acknowledge asks for another byte, and a not-acknowledge ends the read. The data line is open-drain: the block only ever asks for the line to be pulled low.

Top module: `i2c_early_reject_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. It restarts address reception from any state, including partway through a data byte, so a REPEATED START needs no STOP before it.
- R2: The address byte is sent MSB first. Its upper seven bits must equal 7'b1001011, and its least significant bit selects the direction (0 = write, 1 = read). On a match the block pulls SDA low for the whole ninth clock.
- R3: At the first address bit that differs from the target address, the block drops out. It gives no acknowledge, gives no strobe, and ignores all later clocks until the next START.
- R4: In a write, each data byte is taken MSB first on the SCL rising edges. The block acknowledges each byte on the ninth clock and gives a one-cycle rx_valid strobe carrying that byte. Any number of bytes may follow one address with no REPEATED START between them.
- R5: In a read, rd_req pulses for one cycle on the ninth-clock rising edge of the address byte and of every data byte the controller acknowledges. The block loads rd_data at the next SCL falling edge and shifts it out MSB first. sda_oe high means the line is pulled to 0.
- R6: If the controller returns a high level (not-acknowledge) on the ninth clock of a read byte, the read ends. The block then leaves SDA released for all later clocks until the next START.
- R7: A rising SDA while SCL is high is a STOP. It aborts the transfer at any point and releases SDA. A partly received byte gives no strobe, and the block ignores clocks until the next START.
- R8: A rising SDA inside the same SCL high phase as a START is not a STOP. The transfer that the START began goes on as normal.
- R9: sda_oe changes only while the synchronized SCL is low. During every SCL high phase, SDA holds one value.
- R10: After reset, sda_oe, rx_valid and rd_req are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad (wired level) |
| rd_data | input | 8 | Byte to transmit; must be valid from the cycle after rd_req until the next SCL falling edge |
| sda_oe | output | 1 | Pull-down enable for the data pad (1 = drive low) |
| rx_valid | output | 1 | One-cycle strobe for a received write byte |
| rx_data | output | 8 | Received write byte, valid with rx_valid |
| rd_req | output | 1 | One-cycle request for the next read byte |

## Verification
The address stage is driven with a matching byte and with bytes that differ at the first, a middle and the last address bit. The last-bit case catches a comparison that skips bits or is off by one. Bytes sent after a rejected address show whether the block really stays silent. Write bursts with and without a REPEATED START, a REPEATED START partway through a byte, and a read that ends with a not-acknowledge each test a different path out of the data phases. A STOP partway through a byte, followed by clocks with no START, tests the abort. A rising SDA in the same high phase as START must not count as a STOP, and this case sets a rule that honours every STOP apart from a correct detector.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;

    localparam logic [BIT_CNT_W-1:0] CNT_ADDR_DONE = BIT_CNT_W'(ADDR_W);
    localparam logic [BIT_CNT_W-1:0] CNT_BYTE_DONE = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] CNT_LAST_BIT  = BIT_CNT_W'(BYTE_W - 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK
    } phase_e;

    // clock edge events seen in the system clock domain
    typedef struct packed {
        logic rise;
        logic fall;
        logic sda;
    } scl_evt_t;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

    typedef struct packed {
        phase_e                phase;
        logic [BIT_CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0]     shift;
        logic                  rnw;
        logic                  oe;
    } eng_state_t;

    // compare incoming address bit number idx (0 = MSB) against the target
    function automatic logic addr_bit_ok(input logic [ADDR_W-1:0]    addr,
                                         input logic [BIT_CNT_W-1:0] idx,
                                         input logic                 bit_in);
        logic [ADDR_W-1:0] aligned;
        aligned = addr << idx;
        return aligned[ADDR_W-1] == bit_in;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det
    import i2cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output scl_evt_t  evt,
    output bus_cond_t cond
);
    logic scl_d, sda_d;
    logic start_in_high;   // a START happened in the current SCL high phase
    logic start_raw, stop_raw;

    assign start_raw = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_raw  = scl_s & scl_d & ~sda_d & sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d         <= 1'b1;
            sda_d         <= 1'b1;
            start_in_high <= 1'b0;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
            if (start_raw)   start_in_high <= 1'b1;
            else if (!scl_s) start_in_high <= 1'b0;
        end
    end

    always_comb begin
        evt.rise   = scl_s & ~scl_d;
        evt.fall   = ~scl_s & scl_d;
        evt.sda    = sda_s;
        cond.start = start_raw;
        cond.stop  = stop_raw & ~start_in_high;
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'b1001011
) (
    input  logic              clk,
    input  logic              rst,
    input  scl_evt_t          evt,
    input  bus_cond_t         cond,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rd_req
);
    eng_state_t        st, nx;
    logic              rxv_n, rdq_n;
    logic [BYTE_W-1:0] rxd_n;
    logic [BYTE_W-1:0] shifted_in;

    assign shifted_in = {st.shift[BYTE_W-2:0], evt.sda};

    always_comb begin
        nx    = st;
        rxv_n = 1'b0;
        rdq_n = 1'b0;
        rxd_n = rx_data;
        if (cond.start) begin
            nx.phase = PH_ADDR;
            nx.cnt   = '0;
            nx.oe    = 1'b0;
        end else if (cond.stop) begin
            nx.phase = PH_IDLE;
            nx.cnt   = '0;
            nx.oe    = 1'b0;
        end else begin
            unique case (st.phase)
                PH_IDLE: ;
                PH_ADDR: begin
                    if (evt.rise) begin
                        nx.shift = shifted_in;
                        nx.cnt   = st.cnt + 1'b1;
                        if (st.cnt < CNT_ADDR_DONE &&
                            !addr_bit_ok(TARGET_ADDR, st.cnt, evt.sda))
                            nx.phase = PH_IDLE;
                        if (st.cnt == CNT_ADDR_DONE)
                            nx.rnw = evt.sda;
                    end else if (evt.fall && st.cnt == CNT_BYTE_DONE) begin
                        nx.phase = PH_ADDR_ACK;
                        nx.oe    = 1'b1;
                        nx.cnt   = '0;
                    end
                end
                PH_ADDR_ACK: begin
                    if (evt.rise) begin
                        rdq_n = st.rnw;
                    end else if (evt.fall) begin
                        nx.cnt = '0;
                        if (st.rnw) begin
                            nx.phase = PH_RD;
                            nx.shift = rd_data;
                            nx.oe    = ~rd_data[BYTE_W-1];
                        end else begin
                            nx.phase = PH_WR;
                            nx.oe    = 1'b0;
                        end
                    end
                end
                PH_WR: begin
                    if (evt.rise) begin
                        nx.shift = shifted_in;
                        nx.cnt   = st.cnt + 1'b1;
                        if (st.cnt == CNT_LAST_BIT) begin
                            rxv_n = 1'b1;
                            rxd_n = shifted_in;
                        end
                    end else if (evt.fall && st.cnt == CNT_BYTE_DONE) begin
                        nx.phase = PH_WR_ACK;
                        nx.oe    = 1'b1;
                        nx.cnt   = '0;
                    end
                end
                PH_WR_ACK: begin
                    if (evt.fall) begin
                        nx.phase = PH_WR;
                        nx.oe    = 1'b0;
                    end
                end
                PH_RD: begin
                    if (evt.rise) begin
                        nx.cnt = st.cnt + 1'b1;
                    end else if (evt.fall) begin
                        if (st.cnt == CNT_BYTE_DONE) begin
                            nx.phase = PH_RD_ACK;
                            nx.oe    = 1'b0;
                            nx.cnt   = '0;
                        end else begin
                            nx.shift = {st.shift[BYTE_W-2:0], 1'b0};
                            nx.oe    = ~st.shift[BYTE_W-2];
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (evt.rise) begin
                        if (evt.sda) begin
                            nx.phase = PH_IDLE;
                            nx.oe    = 1'b0;
                        end else begin
                            rdq_n = 1'b1;
                        end
                    end else if (evt.fall) begin
                        nx.phase = PH_RD;
                        nx.cnt   = '0;
                        nx.shift = rd_data;
                        nx.oe    = ~rd_data[BYTE_W-1];
                    end
                end
                default: nx.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_IDLE;
            st.cnt   <= '0;
            st.shift <= '0;
            st.rnw   <= 1'b0;
            st.oe    <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rd_req   <= 1'b0;
        end else begin
            st       <= nx;
            rx_valid <= rxv_n;
            rx_data  <= rxd_n;
            rd_req   <= rdq_n;
        end
    end

    assign sda_oe = st.oe;
endmodule

// File: rtl/i2c_early_reject_slave.sv
module i2c_early_reject_slave
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'b1001011,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rd_req
);
    logic [1:0] pins_s;
    logic       scl_s, sda_s;
    scl_evt_t   evt;
    bus_cond_t  cond;
    logic       scl_rise_w, start_w, stop_w;

    i2cs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (pins_s)
    );

    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2cs_cond_det u_det (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt),
        .cond  (cond)
    );

    i2cs_engine #(.TARGET_ADDR(TARGET_ADDR)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cond     (cond),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rd_req   (rd_req)
    );

    assign scl_rise_w = evt.rise;
    assign start_w    = cond.start;
    assign stop_w     = cond.stop;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic scl_rise,
    input logic start_c,
    input logic stop_c,
    input logic sda_oe,
    input logic rx_valid,
    input logic rd_req
);
    // R9
    oe_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R4
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4
    rx_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(scl_rise));

    // R5
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> !sda_oe);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_c |=> !sda_oe);

    // R8
    cond_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_c && stop_c));
endmodule

bind i2c_early_reject_slave i2cs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .scl_rise (scl_rise_w),
    .start_c  (start_w),
    .stop_c   (stop_w),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .rd_req   (rd_req)
);

// File: tb/sim_i2c_early_reject_slave.sv
module sim_i2c_early_reject_slave;

    localparam int Q = 10;   // system clocks per quarter of an SCL period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, rx_valid, rd_req;
    logic [7:0] rx_data;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] rd_next = 8'h5A;
    logic       log_clr = 1'b1;
    int         rx_cnt = 0;
    int         rdq_cnt = 0;
    logic [7:0] rx_hist [16];
    int         checks = 0;
    int         fails = 0;
    int         hi_glitch = 0;
    logic       finished = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_early_reject_slave u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rd_req   (rd_req)
    );

    // logging of strobes and a simple read-data source
    always @(posedge clk) begin
        if (log_clr) begin
            rx_cnt  <= 0;
            rdq_cnt <= 0;
            rd_next <= 8'h5A;
        end else begin
            if (rx_valid) begin
                rx_hist[rx_cnt % 16] <= rx_data;
                rx_cnt <= rx_cnt + 1;
            end
            if (rd_req) begin
                rdq_cnt <= rdq_cnt + 1;
                rd_data <= rd_next;
                rd_next <= rd_next + 8'h11;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        log_clr = 1'b1;
        @(posedge clk); #1;
        log_clr = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw(); qw();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        ack = ~sda_line;
        qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        logic s1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl_m = 1'b1;
            @(posedge clk); #1;
            s1 = sda_line;
            qw();
            b[i] = sda_line;
            repeat (Q - 2) @(posedge clk); #1;
            if (sda_line != s1) hi_glitch++;
            scl_m = 1'b0;
        end
        sda_m = nack; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    // {address byte, data byte, expected address acknowledge}
    localparam logic [16:0] VECS [6] = '{
        {8'h96, 8'h3C, 1'b1},
        {8'h16, 8'h96, 1'b0},
        {8'h96, 8'hFF, 1'b1},
        {8'h94, 8'h55, 1'b0},
        {8'h86, 8'h96, 1'b0},
        {8'h96, 8'h00, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;

        repeat (5) @(posedge clk); #1;
        rst = 1'b0;
        log_clr = 1'b0;
        // R10 reset state
        chk("R10", "sda_oe after reset", sda_oe, 0);
        chk("R10", "rx_valid after reset", rx_valid, 0);
        chk("R10", "rd_req after reset", rd_req, 0);
        qw();

        // R2 / R3 / R4 vector walk
        for (int v = 0; v < 6; v++) begin
            clr();
            bus_start();
            send_byte(VECS[v][16:9], ack);
            chk(VECS[v][0] ? "R2" : "R3", $sformatf("address ack vec%0d", v), ack, VECS[v][0]);
            send_byte(VECS[v][8:1], ack);
            if (VECS[v][0]) begin
                chk("R4", $sformatf("data ack vec%0d", v), ack, 1);
                chk("R4", $sformatf("strobe count vec%0d", v), rx_cnt, 1);
                chk("R4", $sformatf("strobe data vec%0d", v), rx_hist[0], VECS[v][8:1]);
            end else begin
                chk("R3", $sformatf("ignored byte ack vec%0d", v), ack, 0);
                chk("R3", $sformatf("no strobe vec%0d", v), rx_cnt, 0);
            end
            bus_stop();
        end

        // R4 burst without repeated start
        clr();
        bus_start();
        send_byte(8'h96, ack);
        send_byte(8'h11, ack); chk("R4", "burst ack 1", ack, 1);
        send_byte(8'h22, ack); chk("R4", "burst ack 2", ack, 1);
        send_byte(8'h33, ack); chk("R4", "burst ack 3", ack, 1);
        chk("R4", "burst count", rx_cnt, 3);
        chk("R4", "burst last byte", rx_hist[2], 8'h33);
        bus_stop();

        // R1 repeated start between writes
        clr();
        bus_start();
        send_byte(8'h96, ack);
        send_byte(8'h44, ack);
        bus_start();
        send_byte(8'h96, ack); chk("R1", "ack after repeated start", ack, 1);
        send_byte(8'h55, ack);
        chk("R1", "count across repeated start", rx_cnt, 2);
        chk("R1", "byte after repeated start", rx_hist[1], 8'h55);
        bus_stop();

        // R5 / R6 read after command write
        clr();
        bus_start();
        send_byte(8'h96, ack);
        send_byte(8'h01, ack);
        bus_start();
        send_byte(8'h97, ack); chk("R5", "read address ack", ack, 1);
        recv_byte(rb, 1'b0);   chk("R5", "first read byte", rb, 8'h5A);
        recv_byte(rb, 1'b1);   chk("R5", "second read byte", rb, 8'h6B);
        chk("R5", "read request count", rdq_cnt, 2);
        recv_byte(rb, 1'b1);   chk("R6", "bus released after nack", rb, 8'hFF);
        chk("R6", "no request after nack", rdq_cnt, 2);
        chk("R9", "SDA stable in SCL high", hi_glitch, 0);
        bus_stop();

        // R7 stop inside a data byte
        clr();
        bus_start();
        send_byte(8'h96, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R7", "no strobe for partial byte", rx_cnt, 0);
        chk("R7", "released after stop", sda_oe, 0);
        scl_m = 1'b0; qw();
        send_byte(8'h96, ack); chk("R7", "no ack without start", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h96, ack); chk("R7", "ack after new start", ack, 1);
        bus_stop();

        // R8 rising SDA in the START's own high phase
        clr();
        sda_m = 1'b1; scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        sda_m = 1'b1; qw();
        scl_m = 1'b0; qw();
        send_byte(8'h96, ack); chk("R8", "address ack after illegal stop", ack, 1);
        send_byte(8'h77, ack);
        chk("R8", "write accepted", rx_cnt, 1);
        chk("R8", "write data", rx_hist[0], 8'h77);
        bus_stop();

        // R1 repeated start inside a data byte
        clr();
        bus_start();
        send_byte(8'h96, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'h96, ack); chk("R1", "ack after mid-byte restart", ack, 1);
        send_byte(8'h5C, ack);
        chk("R1", "only the complete byte strobed", rx_cnt, 1);
        chk("R1", "byte after mid-byte restart", rx_hist[0], 8'h5C);
        bus_stop();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule